// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller. Its pins are split into two banks, a core bank and a resume bank, and each bank holds its own copy of a set of eight per-pin registers. Software reaches the registers through a byte-wide port with a 6-bit address. Address bit 5 selects the bank, bits 4:2 select the register and bits 1:0 select the byte within it. Pins at or above the split point belong to the resume bank and are numbered from zero again inside it. Bank-local pin n sits in byte n/8 of a register, at bit n mod 8.

Each pin has the following controls: an enable, a direction (1 means input, 0 means output), an output level, separate rising-edge and falling-edge trigger enables, a sticky trigger status, an interrupt enable, and a plain storage bit for a secondary event route. Pin inputs pass through two synchronizing flops before edge detection. The single interrupt output is level-sensitive. It stays high while any pending status bit in either bank has its interrupt enable set.

The register offsets within a bank are: enable 0x00, direction 0x04, level 0x08, rising enable 0x0C, falling enable 0x10, interrupt enable 0x14, storage 0x18, status 0x1C. The core bank is at 0x00 and the resume bank at 0x20.

Top module: `gpio_two_bank`

## Requirements
- R1: After reset, the enable bits are set for core pins 0-6 and for resume-local pins 0-2 and clear for all other pins. Every direction bit reads 1 (input). All other register bits read 0, and neither any output enable nor the interrupt is active.
- R2: Register access follows the address split above. Address bit 5 selects the resume bank, bits 4:2 select the register (enable=0, direction=1, level=2, rising=3, falling=4, interrupt enable=5, storage=6, status=7) and bits 1:0 select the byte. Bank-local pin n is bit n mod 8 of byte n/8.
- R3: A pin's output enable is active only when the pin is enabled and its direction bit is 0.
- R4: A write to the level bit of a pin whose direction bit is 1 is dropped. The same write takes effect once the pin is an output, and the output value follows the stored level.
- R5: Reading the level register returns the synchronized pin input for input pins and the stored level for output pins.
- R6: With its rising enable set, a pin's status is set by a low-to-high input change. With its falling enable set, the status is set by a high-to-low change. With both enables set, either change sets the status. An edge of a kind that is not armed leaves the status unchanged.
- R7: A status bit stays set until software writes 1 to it. Writing 0 to a status bit leaves it unchanged.
- R8: An armed edge sets the status bit even when the pin's interrupt enable is clear. If an edge and a write-1 clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: The interrupt output is high exactly while some status bit in either bank has its interrupt enable set. Clearing the status or the enable lowers it.
- R10: The storage register keeps whatever is written to bits that map to existing pins. Bits and bytes that map to no pin read 0.
- R11: Edges on a pin whose enable bit is 0 do not set its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte address |
| regWrite | input | 1 | Write strobe for the addressed byte |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the addressed byte, combinational |
| pinIn | input | NUM_PINS | Raw pin inputs |
| pinOut | output | NUM_PINS | Pin output values |
| pinOe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Combined level-sensitive interrupt |

## Verification
The status logic serves two writers that can act on the same bit in the same cycle: the edge detector setting it and software clearing it by writing 1. The bench provokes this collision by changing a pin input on a falling clock edge and timing a write-1 clear so that it lands on the third rising edge afterwards. That is the edge on which the synchronized transition reaches the status flop. The read that follows must show the bit still set, and a later clear with no edge must show it cleared.

// File: rtl/gpio2b_pkg.sv
package gpio2b_pkg;

  localparam int REG_COUNT = 8;

  localparam int REG_EN   = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_LVL  = 2;
  localparam int REG_RISE = 3;
  localparam int REG_FALL = 4;
  localparam int REG_IEN  = 5;
  localparam int REG_AUX  = 6;
  localparam int REG_STS  = 7;

  // Write strobes handed from the address decoder to the datapath
  typedef struct packed {
    logic       wr;
    logic       bank;
    logic [1:0] byteSel;
    logic [7:0] regHit;
    logic [7:0] data;
  } strobe_t;

endpackage

// File: rtl/gpio2b_ctrl.sv
module gpio2b_ctrl
  import gpio2b_pkg::*;
(
  input  logic                    regWrite,
  input  logic [5:0]              regAddr,
  input  logic [7:0]              regWdata,
  input  logic [1:0][7:0][31:0]   regView,
  output strobe_t                 stb,
  output logic [7:0]              regRdata
);

  logic       bankSel;
  logic [2:0] regSel;
  logic [1:0] byteSel;

  assign bankSel = regAddr[5];
  assign regSel  = regAddr[4:2];
  assign byteSel = regAddr[1:0];

  always_comb begin
    stb.wr      = regWrite;
    stb.bank    = bankSel;
    stb.byteSel = byteSel;
    stb.data    = regWdata;
    stb.regHit  = regWrite ? (8'b1 << regSel) : 8'b0;
  end

  assign regRdata = regView[bankSel][regSel][{byteSel, 3'b000} +: 8];

endmodule

// File: rtl/gpio2b_dpath.sv
module gpio2b_dpath
  import gpio2b_pkg::*;
#(
  parameter int          NUM_PINS    = 14,
  parameter int          SPLIT       = 10,
  parameter logic [31:0] CORE_EN_RST = 32'h0000_007F,
  parameter logic [31:0] RES_EN_RST  = 32'h0000_0007
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic                  irq,
  output logic [1:0][7:0][31:0] regView,
  output logic [NUM_PINS-1:0]   enVec,
  output logic [NUM_PINS-1:0]   dirVec,
  output logic [NUM_PINS-1:0]   lvlVec,
  output logic [NUM_PINS-1:0]   statVec,
  output logic [NUM_PINS-1:0]   syncVec,
  output logic [NUM_PINS-1:0]   prevVec
);

  localparam int RES_PINS = NUM_PINS - SPLIT;

  logic [NUM_PINS-1:0] riseVec, fallVec, ienVec, auxVec, lvlRead;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam bit   IS_RES = (p >= SPLIT);
    localparam int   LOC    = IS_RES ? (p - SPLIT) : p;
    localparam int   BYTE   = LOC / 8;
    localparam int   BITPOS = LOC % 8;
    localparam logic EN_RST = IS_RES ? RES_EN_RST[LOC] : CORE_EN_RST[LOC];

    logic hit, wBit;
    logic enQ, dirQ, lvlQ, riseQ, fallQ, ienQ, auxQ, stsQ;
    logic meta, syncQ, prevQ;
    logic edgeSeen, clrReq;

    assign hit  = stb.wr && (stb.bank == IS_RES) && (stb.byteSel == 2'(BYTE));
    assign wBit = stb.data[BITPOS];

    // Two-flop synchronizer followed by a history flop for edge detection
    always_ff @(posedge clk) begin
      if (!rstN) begin
        meta  <= 1'b0;
        syncQ <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        meta  <= pinIn[p];
        syncQ <= meta;
        prevQ <= syncQ;
      end
    end

    assign edgeSeen = enQ && ((riseQ && syncQ && !prevQ) || (fallQ && !syncQ && prevQ));
    assign clrReq   = hit && stb.regHit[REG_STS] && wBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ   <= EN_RST;
        dirQ  <= 1'b1;
        lvlQ  <= 1'b0;
        riseQ <= 1'b0;
        fallQ <= 1'b0;
        ienQ  <= 1'b0;
        auxQ  <= 1'b0;
        stsQ  <= 1'b0;
      end else begin
        if (hit && stb.regHit[REG_EN])            enQ   <= wBit;
        if (hit && stb.regHit[REG_DIR])           dirQ  <= wBit;
        if (hit && stb.regHit[REG_LVL] && !dirQ)  lvlQ  <= wBit;
        if (hit && stb.regHit[REG_RISE])          riseQ <= wBit;
        if (hit && stb.regHit[REG_FALL])          fallQ <= wBit;
        if (hit && stb.regHit[REG_IEN])           ienQ  <= wBit;
        if (hit && stb.regHit[REG_AUX])           auxQ  <= wBit;
        // a fresh edge takes priority over a clear in the same cycle
        stsQ <= edgeSeen || (stsQ && !clrReq);
      end
    end

    assign enVec[p]   = enQ;
    assign dirVec[p]  = dirQ;
    assign lvlVec[p]  = lvlQ;
    assign riseVec[p] = riseQ;
    assign fallVec[p] = fallQ;
    assign ienVec[p]  = ienQ;
    assign auxVec[p]  = auxQ;
    assign statVec[p] = stsQ;
    assign syncVec[p] = syncQ;
    assign prevVec[p] = prevQ;
    assign lvlRead[p] = dirQ ? syncQ : lvlQ;
    assign pinOe[p]   = enQ && !dirQ;
    assign pinOut[p]  = lvlQ;
  end

  assign irq = |(statVec & ienVec);

  logic [REG_COUNT-1:0][NUM_PINS-1:0] allRegs;

  always_comb begin
    allRegs[REG_EN]   = enVec;
    allRegs[REG_DIR]  = dirVec;
    allRegs[REG_LVL]  = lvlRead;
    allRegs[REG_RISE] = riseVec;
    allRegs[REG_FALL] = fallVec;
    allRegs[REG_IEN]  = ienVec;
    allRegs[REG_AUX]  = auxVec;
    allRegs[REG_STS]  = statVec;
    for (int r = 0; r < REG_COUNT; r++) begin
      regView[0][r] = 32'(allRegs[r][SPLIT-1:0]);
      regView[1][r] = 32'(allRegs[r][NUM_PINS-1:SPLIT]);
    end
  end

  if (RES_PINS < 1 || RES_PINS > 32 || SPLIT > 32) begin : g_bad_split
    initial $error("gpio2b_dpath: bank sizes must be 1..32 pins");
  end

endmodule

// File: rtl/gpio_two_bank.sv
module gpio_two_bank
  import gpio2b_pkg::*;
#(
  parameter int          NUM_PINS    = 14,
  parameter int          SPLIT       = 10,
  parameter logic [31:0] CORE_EN_RST = 32'h0000_007F,
  parameter logic [31:0] RES_EN_RST  = 32'h0000_0007
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [5:0]          regAddr,
  input  logic                regWrite,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq
);

  strobe_t                 stb;
  logic [1:0][7:0][31:0]   regView;
  logic [NUM_PINS-1:0]     enVec, dirVec, lvlVec, statVec, syncVec, prevVec;

  gpio2b_ctrl u_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regView  (regView),
    .stb      (stb),
    .regRdata (regRdata)
  );

  gpio2b_dpath #(
    .NUM_PINS    (NUM_PINS),
    .SPLIT       (SPLIT),
    .CORE_EN_RST (CORE_EN_RST),
    .RES_EN_RST  (RES_EN_RST)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irq     (irq),
    .regView (regView),
    .enVec   (enVec),
    .dirVec  (dirVec),
    .lvlVec  (lvlVec),
    .statVec (statVec),
    .syncVec (syncVec),
    .prevVec (prevVec)
  );

endmodule

// File: rtl/gpio2b_chk.sv
module gpio2b_chk #(
  parameter int NUM_PINS = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrite,
  input logic                irq,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] dirVec,
  input logic [NUM_PINS-1:0] lvlVec,
  input logic [NUM_PINS-1:0] statVec,
  input logic [NUM_PINS-1:0] syncVec,
  input logic [NUM_PINS-1:0] prevVec
);

  AST_LEVEL_HELD_ON_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    ((lvlVec ^ $past(lvlVec)) & $past(dirVec)) == '0);  // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrite) |-> (($past(statVec) & ~statVec) == '0));  // R7

  AST_STATUS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ((statVec & ~$past(statVec)) != '0) |-> ($past(syncVec) != $past(prevVec)));  // R6

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irq) && !$past(regWrite)) |-> irq);  // R9

  AST_OE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~$past(pinOe)) != '0) |-> $past(regWrite));  // R3

endmodule

bind gpio_two_bank gpio2b_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrite (regWrite),
  .irq      (irq),
  .pinOe    (pinOe),
  .dirVec   (dirVec),
  .lvlVec   (lvlVec),
  .statVec  (statVec),
  .syncVec  (syncVec),
  .prevVec  (prevVec)
);

// File: tb/tb_gpio_two_bank.sv
module tb_gpio_two_bank;

  localparam int NUM_PINS = 14;
  localparam int K_READ = 0, K_OE = 1, K_OUT = 2, K_IRQ = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [5:0]          regAddr = '0;
  logic                regWrite = 1'b0;
  logic [7:0]          regWdata = '0;
  logic [7:0]          regRdata;
  logic [NUM_PINS-1:0] pinIn = '0;
  logic [NUM_PINS-1:0] pinOut, pinOe;
  logic                irq;

  int    nChecks = 0;
  int    nFails  = 0;
  item_t sbq[$];
  event  kick;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  gpio_two_bank dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // Monitor: pops the expected item and compares it a little after the driver sets up
  initial begin
    forever begin
      @(kick);
      #2;
      while (sbq.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.kind)
          K_READ:  act = 32'(regRdata);
          K_OE:    act = 32'(pinOe);
          K_OUT:   act = 32'(pinOut);
          default: act = 32'(irq);
        endcase
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    -> kick;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    push(K_READ, 32'(exp), tag);
  endtask

  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    @(negedge clk);
    push(kind, exp, tag);
  endtask

  task automatic setPin(input int idx, input logic v);
    @(negedge clk);
    pinIn[idx] = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(6'h00, 8'h7F, "R1 core enable byte0");
    rd(6'h01, 8'h00, "R1 core enable byte1");
    rd(6'h20, 8'h07, "R1 resume enable");
    rd(6'h04, 8'hFF, "R1 core direction byte0");
    rd(6'h05, 8'h03, "R1 core direction byte1");
    rd(6'h24, 8'h0F, "R1 resume direction");
    rd(6'h1C, 8'h00, "R1 status");
    chk(K_OE, 32'h0, "R1 no output enable");
    chk(K_IRQ, 32'h0, "R1 irq low");

    // R2 byte/bit mapping and bank offset
    wr(6'h01, 8'h02);
    rd(6'h01, 8'h02, "R2 core pin9 enable in byte1 bit1");
    wr(6'h20, 8'h0F);
    rd(6'h20, 8'h0F, "R2 resume bank at 0x20");

    // R3 output enable needs enable and output direction (pin8 stays disabled)
    wr(6'h04, 8'hFE);
    wr(6'h05, 8'h00);
    wr(6'h24, 8'h07);
    chk(K_OE, 32'h2201, "R3 output enables");
    rd(6'h05, 8'h00, "R3 direction byte1");

    // R4 level writes dropped on input pins
    wr(6'h08, 8'h03);
    chk(K_OUT, 32'h0001, "R4 pin1 level write dropped");
    wr(6'h04, 8'hFC);
    wr(6'h08, 8'h03);
    chk(K_OUT, 32'h0003, "R4 level accepted after switch to output");

    // R5 level read mixes inputs and stored outputs
    @(negedge clk);
    pinIn[3] = 1'b1; pinIn[12] = 1'b1;
    repeat (3) @(posedge clk);
    rd(6'h08, 8'h0B, "R5 core level read");
    rd(6'h28, 8'h04, "R5 resume level read");

    // R6 rising on pin4, falling on pin5, both on pin6
    wr(6'h0C, 8'h50);
    wr(6'h10, 8'h60);
    setPin(4, 1'b1);
    rd(6'h1C, 8'h10, "R6 rising edge pin4");
    setPin(5, 1'b1);
    rd(6'h1C, 8'h10, "R6 unarmed rising pin5");
    setPin(5, 1'b0);
    rd(6'h1C, 8'h30, "R6 falling edge pin5");
    setPin(4, 1'b0);
    rd(6'h1C, 8'h30, "R6 unarmed falling pin4");
    setPin(6, 1'b1);
    rd(6'h1C, 8'h70, "R6 both-edge rise pin6");

    // R7 write-one-to-clear
    wr(6'h1C, 8'h00);
    rd(6'h1C, 8'h70, "R7 write zero keeps status");
    wr(6'h1C, 8'h50);
    rd(6'h1C, 8'h20, "R7 write one clears");
    setPin(6, 1'b0);
    rd(6'h1C, 8'h60, "R6 both-edge fall pin6");
    wr(6'h1C, 8'h60);
    rd(6'h1C, 8'h00, "R7 cleared all");

    // R8 edge and clear in the same cycle: set wins; no interrupt enable needed
    @(negedge clk);
    pinIn[4] = 1'b1;
    repeat (2) @(posedge clk);
    wr(6'h1C, 8'h10);
    rd(6'h1C, 8'h10, "R8 set wins over clear");
    chk(K_IRQ, 32'h0, "R8 status without irq enable");
    wr(6'h1C, 8'h10);
    rd(6'h1C, 8'h00, "R8 later clear");

    // R9 interrupt aggregation across banks
    wr(6'h14, 8'h10);
    chk(K_IRQ, 32'h0, "R9 enable without status");
    wr(6'h2C, 8'h04);
    wr(6'h34, 8'h04);
    setPin(12, 1'b0);
    setPin(12, 1'b1);
    rd(6'h3C, 8'h04, "R9 resume status");
    chk(K_IRQ, 32'h1, "R9 irq from resume bank");
    wr(6'h3C, 8'h04);
    chk(K_IRQ, 32'h0, "R9 irq drops on clear");
    setPin(4, 1'b0);
    setPin(4, 1'b1);
    chk(K_IRQ, 32'h1, "R9 irq from core bank");
    wr(6'h14, 8'h00);
    chk(K_IRQ, 32'h0, "R9 irq drops on mask");
    rd(6'h1C, 8'h10, "R9 status kept when masked");
    wr(6'h1C, 8'h10);

    // R10 storage register and unmapped bytes
    wr(6'h18, 8'hA5);
    rd(6'h18, 8'hA5, "R10 storage byte0");
    wr(6'h19, 8'hFF);
    rd(6'h19, 8'h03, "R10 storage byte1 only two pins");
    rd(6'h1A, 8'h00, "R10 unmapped byte");
    wr(6'h38, 8'hFF);
    rd(6'h38, 8'h0F, "R10 resume storage");

    // R11 disabled pin ignores edges
    wr(6'h0D, 8'h01);
    setPin(8, 1'b1);
    rd(6'h1D, 8'h00, "R11 disabled pin8 edge ignored");
    wr(6'h01, 8'h03);
    setPin(8, 1'b0);
    setPin(8, 1'b1);
    rd(6'h1D, 8'h01, "R11 enabled pin8 edge captured");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule